// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block is the central scheduler of a pipeline whose register names have already been mapped to physical tags. Decoded instructions arrive one at a time in program order. Each carries two source tags, a destination tag and a functional-unit class. The scheduler keeps one pending-result bit per physical tag and one occupied flag per functional unit. An instruction passes through two internal slots. In the issue slot it waits for a free unit of its class. Once it leaves that slot, the unit is reserved and the destination tag is marked pending. In the read slot it waits until both source tags are no longer pending, then it is dispatched to its unit.

Units can finish in any order. Each unit has its own writeback port that reports completion and the tag written. A completion frees the unit and clears the pending bit of that tag. There is no forwarding path, so a consumer only reads after the producer's result has reached the register file. Write-after-read and write-after-write conflicts are never checked, because every destination is a fresh physical tag. A flush input empties both slots and clears all pending bits and unit flags, which rolls the scheduler back.

Top module: `issb_sched`

## Requirements
- R1: Instructions are dispatched on `rd_fire` strictly in acceptance order, with the tags they were accepted with. An instruction stalled in either slot blocks every younger one.
- R2: An instruction is dispatched only to a unit of its class that is not reserved. A unit stays reserved from issue until the cycle its `wb_valid` bit is high. A class with every unit reserved stalls issue.
- R3: An instruction is never dispatched while either of its source tags has a result outstanding.
- R4: There is no forwarding. In the cycle a writeback names one of the sources of the waiting read-slot instruction, `rd_fire` stays low.
- R5: The pending bit of a tag is set when its producer issues and cleared by its writeback. A consumer that waits only on that tag dispatches in the cycle right after the writeback.
- R6: During a flush cycle `in_ready` and `rd_fire` are low. All pending bits and unit flags are cleared. An instruction accepted one cycle after the flush, whose source was pending before the flush, dispatches two cycles after acceptance.
- R7: With free sources and a free unit, an instruction accepted in cycle n dispatches in cycle n+2. Independent instructions accepted back to back dispatch in consecutive cycles.
- R8: After reset `in_ready` is high, `rd_fire` is low and every tag and unit is free.
- R9: Units are numbered class by class. Unit u belongs to class u / UNITS_PER_CLASS, and `rd_unit` gives the number of the unit the instruction was granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Rollback: empties slots, clears all pending bits and unit flags |
| in_valid | input | 1 | A decoded instruction is offered |
| in_ready | output | 1 | The offered instruction is accepted this cycle |
| in_src_a | input | TAG_W | First source physical tag |
| in_src_b | input | TAG_W | Second source physical tag |
| in_dst | input | TAG_W | Destination physical tag (fresh) |
| in_cls | input | bits_for(NUM_CLASSES) | Functional-unit class, below NUM_CLASSES |
| rd_fire | output | 1 | Read-slot instruction reads operands and goes to its unit this cycle |
| rd_unit | output | bits_for(NUM_CLASSES*UNITS_PER_CLASS) | Unit granted to the dispatched instruction |
| rd_src_a | output | TAG_W | First source tag of the dispatched instruction |
| rd_src_b | output | TAG_W | Second source tag of the dispatched instruction |
| rd_dst | output | TAG_W | Destination tag of the dispatched instruction |
| wb_valid | input | NUM_CLASSES*UNITS_PER_CLASS | Per-unit completion strobe |
| wb_tag | input | NUM_CLASSES*UNITS_PER_CLASS*TAG_W | Per-unit tag written, unit u at bits u*TAG_W upward |

## Verification
The assertions assume several things about the inputs. An issued destination tag is not already pending. A writeback only comes from a unit that holds a dispatched instruction, and it names that instruction's pending destination. The class code is in range, and no instruction names its own destination as a source. The stimulus picks each destination from a bench-side set of tags that are neither queued nor in flight. It derives every writeback from a dispatch it saw on `rd_fire`, with that instruction's destination tag and a chosen latency. On a flush it drops all in-flight work, so no stale writeback reaches a unit after it has been cleared.

// File: rtl/issb_pkg.sv
package issb_pkg;

   // Width of an index able to name n items, never below one bit.
   function automatic int bits_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Units are numbered class by class.
   function automatic int class_of_unit(input int unit_idx, input int per_class);
      return unit_idx / per_class;
   endfunction

endpackage

// File: rtl/issb_busy_table.sv
module issb_busy_table
   import issb_pkg::*;
#(
   parameter int TAG_W = 4,
   parameter int NWB   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               set_en,
   input  logic [TAG_W-1:0]   set_tag,
   input  logic [NWB-1:0]     wb_valid,
   input  logic [NWB*TAG_W-1:0] wb_tag,
   input  logic [TAG_W-1:0]   qa_tag,
   input  logic [TAG_W-1:0]   qb_tag,
   output logic               qa_busy,
   output logic               qb_busy
);

   localparam int NREG = 1 << TAG_W;

   if (TAG_W < 1 || TAG_W > 10) begin : g_bad_tag_w
      $error("issb_busy_table: TAG_W out of supported range");
   end
   if (NWB < 1) begin : g_bad_nwb
      $error("issb_busy_table: needs at least one writeback port");
   end

   logic [NREG-1:0] busy_q;
   logic [NREG-1:0] clr_mask;
   logic [NREG-1:0] set_mask;

   always_comb begin
      clr_mask = '0;
      for (int i = 0; i < NWB; i++) begin
         if (wb_valid[i]) clr_mask[wb_tag[i*TAG_W +: TAG_W]] = 1'b1;
      end
      set_mask = '0;
      if (set_en) set_mask[set_tag] = 1'b1;
   end

   // Writebacks clear, a fresh issue sets; the registered value is what
   // the read slot sees, so a same-cycle writeback is not bypassed.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
      end else if (flush) begin
         busy_q <= '0;
      end else begin
         busy_q <= (busy_q & ~clr_mask) | set_mask;
      end
   end

   assign qa_busy = busy_q[qa_tag];
   assign qb_busy = busy_q[qb_tag];

   AST_FRESH_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      set_en && !flush |-> !busy_q[set_tag]); // R5

   for (genvar i = 0; i < NWB; i++) begin : g_wb_chk
      AST_WB_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
         wb_valid[i] && !flush |-> busy_q[wb_tag[i*TAG_W +: TAG_W]]); // R5
   end

endmodule

// File: rtl/issb_unit_pool.sv
module issb_unit_pool
   import issb_pkg::*;
#(
   parameter int NUM_CLASSES     = 3,
   parameter int UNITS_PER_CLASS = 2,
   parameter bit PICK_LOW        = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic alloc,
   input  logic [bits_for(NUM_CLASSES)-1:0] req_cls,
   output logic avail,
   output logic [bits_for(NUM_CLASSES*UNITS_PER_CLASS)-1:0] grant_unit,
   input  logic [NUM_CLASSES*UNITS_PER_CLASS-1:0] wb_valid
);

   localparam int NUNIT  = NUM_CLASSES * UNITS_PER_CLASS;
   localparam int CLS_W  = bits_for(NUM_CLASSES);
   localparam int UIDX_W = bits_for(NUNIT);

   if (NUM_CLASSES < 1 || UNITS_PER_CLASS < 1) begin : g_bad_shape
      $error("issb_unit_pool: need at least one class and one unit per class");
   end
   if (NUNIT > 256) begin : g_bad_size
      $error("issb_unit_pool: too many units");
   end

   logic [NUNIT-1:0]  occ_q;
   logic [NUNIT-1:0]  grant_mask;
   logic [NUM_CLASSES-1:0] cls_any;
   logic [UIDX_W-1:0] cls_pick [NUM_CLASSES];

   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
      logic              any_l;
      logic [UIDX_W-1:0] pick_l;

      if (PICK_LOW) begin : g_low
         // Scan from the top so the lowest free unit is written last.
         always_comb begin
            any_l  = 1'b0;
            pick_l = '0;
            for (int k = UNITS_PER_CLASS - 1; k >= 0; k--) begin
               if (!occ_q[c*UNITS_PER_CLASS + k]) begin
                  any_l  = 1'b1;
                  pick_l = UIDX_W'(c*UNITS_PER_CLASS + k);
               end
            end
         end
      end else begin : g_high
         always_comb begin
            any_l  = 1'b0;
            pick_l = '0;
            for (int k = 0; k < UNITS_PER_CLASS; k++) begin
               if (!occ_q[c*UNITS_PER_CLASS + k]) begin
                  any_l  = 1'b1;
                  pick_l = UIDX_W'(c*UNITS_PER_CLASS + k);
               end
            end
         end
      end

      assign cls_any[c]  = any_l;
      assign cls_pick[c] = pick_l;
   end

   always_comb begin
      avail      = 1'b0;
      grant_unit = '0;
      for (int c = 0; c < NUM_CLASSES; c++) begin
         if (req_cls == CLS_W'(c)) begin
            avail      = cls_any[c];
            grant_unit = cls_pick[c];
         end
      end
      grant_mask = '0;
      if (alloc) grant_mask[grant_unit] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q <= '0;
      end else if (flush) begin
         occ_q <= '0;
      end else begin
         occ_q <= (occ_q & ~wb_valid) | grant_mask;
      end
   end

   AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> avail && !occ_q[grant_unit]); // R2

   AST_GRANT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (int'(grant_unit) / UNITS_PER_CLASS) == int'(req_cls)); // R9

   AST_HELD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      alloc && !flush |=> occ_q[$past(grant_unit)]); // R2

   for (genvar u = 0; u < NUNIT; u++) begin : g_wb_chk
      AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         wb_valid[u] && !flush |-> occ_q[u]); // R2
   end

endmodule

// File: rtl/issb_sched.sv
module issb_sched
   import issb_pkg::*;
#(
   parameter int TAG_W           = 4,
   parameter int NUM_CLASSES     = 3,
   parameter int UNITS_PER_CLASS = 2,
   parameter bit PICK_LOW        = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic in_valid,
   output logic in_ready,
   input  logic [TAG_W-1:0] in_src_a,
   input  logic [TAG_W-1:0] in_src_b,
   input  logic [TAG_W-1:0] in_dst,
   input  logic [bits_for(NUM_CLASSES)-1:0] in_cls,
   output logic rd_fire,
   output logic [bits_for(NUM_CLASSES*UNITS_PER_CLASS)-1:0] rd_unit,
   output logic [TAG_W-1:0] rd_src_a,
   output logic [TAG_W-1:0] rd_src_b,
   output logic [TAG_W-1:0] rd_dst,
   input  logic [NUM_CLASSES*UNITS_PER_CLASS-1:0] wb_valid,
   input  logic [NUM_CLASSES*UNITS_PER_CLASS*TAG_W-1:0] wb_tag
);

   localparam int NUNIT  = NUM_CLASSES * UNITS_PER_CLASS;
   localparam int CLS_W  = bits_for(NUM_CLASSES);
   localparam int UIDX_W = bits_for(NUNIT);

   // Issue slot: waits for a free unit of its class.
   logic              iss_v;
   logic [TAG_W-1:0]  iss_a, iss_b, iss_d;
   logic [CLS_W-1:0]  iss_c;

   // Read slot: waits for both sources to be written.
   logic              rd_v;
   logic [TAG_W-1:0]  rd_a, rd_b, rd_d;
   logic [UIDX_W-1:0] rd_u;

   logic unit_avail;
   logic [UIDX_W-1:0] unit_grant;
   logic busy_a, busy_b;
   logic iss_go;

   assign rd_fire  = rd_v && !flush && !busy_a && !busy_b;
   assign iss_go   = iss_v && !flush && unit_avail && (!rd_v || rd_fire);
   assign in_ready = !flush && (!iss_v || iss_go);

   issb_busy_table #(
      .TAG_W (TAG_W),
      .NWB   (NUNIT)
   ) i_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .set_en   (iss_go),
      .set_tag  (iss_d),
      .wb_valid (wb_valid),
      .wb_tag   (wb_tag),
      .qa_tag   (rd_a),
      .qb_tag   (rd_b),
      .qa_busy  (busy_a),
      .qb_busy  (busy_b)
   );

   issb_unit_pool #(
      .NUM_CLASSES     (NUM_CLASSES),
      .UNITS_PER_CLASS (UNITS_PER_CLASS),
      .PICK_LOW        (PICK_LOW)
   ) i_units (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc      (iss_go),
      .req_cls    (iss_c),
      .avail      (unit_avail),
      .grant_unit (unit_grant),
      .wb_valid   (wb_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iss_v <= 1'b0;
         iss_a <= '0;
         iss_b <= '0;
         iss_d <= '0;
         iss_c <= '0;
      end else if (flush) begin
         iss_v <= 1'b0;
      end else if (in_valid && in_ready) begin
         iss_v <= 1'b1;
         iss_a <= in_src_a;
         iss_b <= in_src_b;
         iss_d <= in_dst;
         iss_c <= in_cls;
      end else if (iss_go) begin
         iss_v <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_v <= 1'b0;
         rd_a <= '0;
         rd_b <= '0;
         rd_d <= '0;
         rd_u <= '0;
      end else if (flush) begin
         rd_v <= 1'b0;
      end else if (iss_go) begin
         rd_v <= 1'b1;
         rd_a <= iss_a;
         rd_b <= iss_b;
         rd_d <= iss_d;
         rd_u <= unit_grant;
      end else if (rd_fire) begin
         rd_v <= 1'b0;
      end
   end

   assign rd_unit  = rd_u;
   assign rd_src_a = rd_a;
   assign rd_src_b = rd_b;
   assign rd_dst   = rd_d;

   AST_HOLD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      rd_v && !rd_fire && !flush |=> rd_v && $stable(rd_dst) && $stable(rd_unit)); // R1

   AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !in_ready && !rd_fire); // R6

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !rd_fire); // R6

   AST_CLS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> int'(in_cls) < NUM_CLASSES); // R2

   AST_NO_SELF_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> in_src_a != in_dst && in_src_b != in_dst); // R3

   for (genvar u = 0; u < NUNIT; u++) begin : g_fwd_chk
      AST_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
         rd_fire |-> !(wb_valid[u] && (wb_tag[u*TAG_W +: TAG_W] == rd_src_a ||
                                      wb_tag[u*TAG_W +: TAG_W] == rd_src_b))); // R4
   end

endmodule

// File: tb/test_issb_sched.sv
`timescale 1ns/1ps
module test_issb_sched;

   localparam int TAG_W = 4;
   localparam int NTAG  = 16;
   localparam int NCLS  = 3;
   localparam int UPC   = 2;
   localparam int NUNIT = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [3:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
   logic [1:0] in_cls = '0;
   logic rd_fire;
   logic [2:0] rd_unit;
   logic [3:0] rd_src_a, rd_src_b, rd_dst;
   logic [NUNIT-1:0] wb_valid = '0;
   logic [NUNIT*TAG_W-1:0] wb_tag = '0;

   always #2 clk = ~clk;

   issb_sched #(.TAG_W(TAG_W), .NUM_CLASSES(NCLS), .UNITS_PER_CLASS(UPC)) i_issb_sched (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_cls(in_cls),
      .rd_fire(rd_fire), .rd_unit(rd_unit),
      .rd_src_a(rd_src_a), .rd_src_b(rd_src_b), .rd_dst(rd_dst),
      .wb_valid(wb_valid), .wb_tag(wb_tag));

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // Reference model state
   int q_a[64], q_b[64], q_d[64], q_c[64];
   int q_h = 0, q_n = 0;
   bit busy_m[NTAG];
   bit inuse[NTAG];
   bit held[8];
   int cnt[8];
   int htag[8];
   bit wbv[8];
   int next_lat = 3;
   int stall = 0;
   bit fire_now, acc_now;
   int fire_dst_now;
   int recent[4];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int cls_of(input int u);
      return u / UPC;
   endfunction

   function automatic bit wb_hits(input int tag);
      for (int u = 0; u < NUNIT; u++) if (wbv[u] && htag[u] == tag) return 1'b1;
      return 1'b0;
   endfunction

   function automatic int fresh_tag(input int start);
      for (int k = 0; k < NTAG; k++) if (!inuse[(start + k) % NTAG]) return (start + k) % NTAG;
      return -1;
   endfunction

   task automatic clear_model();
      q_n = 0;
      for (int t = 0; t < NTAG; t++) begin busy_m[t] = 0; inuse[t] = 0; end
      for (int u = 0; u < 8; u++) begin held[u] = 0; cnt[u] = 0; end
   endtask

   // One cycle: drive at the falling edge, then sample and update the model.
   task automatic step(input bit v, input int a, input int b, input int d, input int c, input bit fl);
      @(negedge clk);
      in_valid = v; in_src_a = 4'(a); in_src_b = 4'(b); in_dst = 4'(d); in_cls = 2'(c);
      flush = fl;
      for (int u = 0; u < NUNIT; u++) begin
         wbv[u] = 1'b0;
         if (held[u]) begin
            cnt[u]--;
            if (cnt[u] == 0) wbv[u] = 1'b1;
         end
         wb_valid[u] = wbv[u];
         wb_tag[u*TAG_W +: TAG_W] = 4'(htag[u]);
      end
      #1;
      fire_now = rd_fire;
      fire_dst_now = int'(rd_dst);
      acc_now = v && in_ready;
      if (fl) begin
         chk(!in_ready, "R6 in_ready during flush", in_ready, 0);
         chk(!rd_fire, "R6 rd_fire during flush", rd_fire, 0);
      end
      if (rd_fire) begin
         if (q_n == 0) chk(1'b0, "R1 dispatch with nothing queued", 1, 0);
         else begin
            chk(int'(rd_dst) == q_d[q_h] && int'(rd_src_a) == q_a[q_h] && int'(rd_src_b) == q_b[q_h],
                "R1 program order dst", int'(rd_dst), q_d[q_h]);
            chk(cls_of(int'(rd_unit)) == q_c[q_h], "R9 unit class", cls_of(int'(rd_unit)), q_c[q_h]);
            chk(!held[rd_unit], "R2 unit already reserved", int'(rd_unit), -1);
            if (wb_hits(int'(rd_src_a)) || wb_hits(int'(rd_src_b)))
               chk(1'b0, "R4 read on writeback cycle", 1, 0);
            else
               chk(!busy_m[rd_src_a] && !busy_m[rd_src_b], "R3 source pending",
                   int'(busy_m[rd_src_a]) + int'(busy_m[rd_src_b]), 0);
         end
      end
      for (int u = 0; u < NUNIT; u++) if (wbv[u]) begin
         held[u] = 0; busy_m[htag[u]] = 0; inuse[htag[u]] = 0;
      end
      if (rd_fire && q_n > 0) begin
         busy_m[rd_dst] = 1; held[rd_unit] = 1; cnt[rd_unit] = next_lat; htag[rd_unit] = int'(rd_dst);
         q_h = (q_h + 1) % 64; q_n--;
      end
      if (acc_now) begin
         q_a[(q_h + q_n) % 64] = a; q_b[(q_h + q_n) % 64] = b;
         q_d[(q_h + q_n) % 64] = d; q_c[(q_h + q_n) % 64] = c;
         q_n++; inuse[d] = 1;
      end
      if (fl) clear_model();
      if (q_n > 0 && !rd_fire) stall++; else stall = 0;
      if (stall == 100) chk(1'b0, "R1 no forward progress", stall, 0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 1, 2, 0, 0);
   endtask

   task automatic expect_fire(input bit exp, input int dst, input string req);
      chk(fire_now == exp && (!exp || fire_dst_now == dst), req,
          fire_now ? fire_dst_now : -1, exp ? dst : -1);
   endtask

   initial begin
      int da[4];
      void'($urandom(32'd20240611));
      clear_model();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(in_ready, "R8 in_ready after reset", in_ready, 1);
      chk(!rd_fire, "R8 rd_fire after reset", rd_fire, 0);

      // Producer/consumer through the pending bit, no forwarding
      next_lat = 5;
      step(1, 1, 2, 5, 0, 0); chk(acc_now, "R7 accept producer", acc_now, 1);
      step(1, 5, 3, 6, 1, 0); chk(acc_now, "R7 accept consumer", acc_now, 1);
      step(0, 0, 1, 2, 0, 0); expect_fire(1, 5, "R7 producer dispatch at n+2");
      next_lat = 2;
      for (int k = 3; k <= 6; k++) begin
         step(0, 0, 1, 2, 0, 0); expect_fire(0, 0, "R3 consumer waits on pending source");
      end
      step(0, 0, 1, 2, 0, 0); expect_fire(0, 0, "R4 no read on writeback cycle");
      step(0, 0, 1, 2, 0, 0); expect_fire(1, 6, "R5 consumer dispatches after writeback");
      idle(10);

      // Back-to-back independent instructions
      next_lat = 3;
      da = '{7, 8, 10, 11};
      for (int k = 0; k < 8; k++) begin
         if (k < 4) step(1, 1, 2, da[k], (k == 3) ? 0 : k, 0); else step(0, 0, 1, 2, 0, 0);
         if (k >= 2 && k <= 5) expect_fire(1, da[k-2], "R7 one dispatch per cycle");
         else expect_fire(0, 0, "R7 no extra dispatch");
      end
      idle(10);

      // Class with both units reserved stalls issue
      next_lat = 20;
      for (int k = 0; k < 26; k++) begin
         if (k < 3) step(1, 1, 2, 12 + k, 2, 0); else step(0, 0, 1, 2, 0, 0);
         if (k == 2) expect_fire(1, 12, "R2 first unit");
         else if (k == 3) expect_fire(1, 13, "R2 second unit");
         else if (k == 24) expect_fire(1, 14, "R2 third waits for a writeback");
         else expect_fire(0, 0, "R2 class full stalls");
      end
      idle(25);

      // Flush clears pending bits and slots
      next_lat = 30;
      step(1, 1, 2, 9, 0, 0);
      step(1, 9, 3, 15, 1, 0);
      idle(3);
      step(0, 0, 1, 2, 0, 1);
      step(1, 9, 3, 4, 0, 0); expect_fire(0, 0, "R6 empty after flush");
      chk(acc_now, "R6 accept after flush", acc_now, 1);
      step(0, 0, 1, 2, 0, 0); expect_fire(0, 0, "R6 not yet");
      step(0, 0, 1, 2, 0, 0); expect_fire(1, 4, "R6 source freed by flush");
      idle(10);

      // Constrained random traffic
      for (int i = 0; i < 4; i++) recent[i] = i;
      for (int n = 0; n < 6000; n++) begin
         int d, a, b, c;
         bit v, fl;
         next_lat = 1 + int'($urandom_range(7));
         fl = ($urandom_range(299) == 0);
         d = fresh_tag(int'($urandom_range(NTAG - 1)));
         v = ($urandom_range(9) < 7) && d >= 0 && !fl;
         if (d < 0) d = 0;
         a = ($urandom_range(1) == 1) ? recent[$urandom_range(3)] : int'($urandom_range(NTAG - 1));
         b = ($urandom_range(1) == 1) ? recent[$urandom_range(3)] : int'($urandom_range(NTAG - 1));
         if (a == d) a = (d + 1) % NTAG;
         if (b == d) b = (d + 2) % NTAG;
         c = int'($urandom_range(NCLS - 1));
         step(v, a, b, d, c, fl);
         if (acc_now) begin
            for (int k = 3; k > 0; k--) recent[k] = recent[k-1];
            recent[0] = d;
         end
      end
      idle(40);
      chk(q_n == 0, "R1 all accepted work dispatched", q_n, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R1 watchdog expired: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule